// File: doc/BRIEF.md
# Synchronous Up/Down Decade Counter

This block is one BCD digit that counts up or down. It has two separate count inputs. Both are active on a rising edge and sit high when idle. The block samples them on a system clock and detects their edges there. A count is taken only when one input rises while the other stays high. A master clear sets the digit to zero. A level-sensitive, active-low parallel load can preset the digit to any four-bit code, including the six codes above nine. From those codes the digit returns to the decade sequence along a fixed path.

Two active-low outputs let digits be chained. The terminal-up output falls while count-up is low at nine. The terminal-down output falls while count-down is low at zero. Each one rises again together with the count input that caused it. Connect them to the count-up and count-down inputs of the next digit. Two stages then span 00 to 99 in both directions. Clear and load take effect on the next system clock edge. A qualified count edge changes the digit on the clock edge where the new high level is first sampled.

Top module: `bcd_updn_counter`

## Requirements
- R1: With `clr` high, `q` becomes 0 on the next clock edge, whatever `load_n`, `din` and the count inputs do.
- R2: With `clr` low and `load_n` low, `q` takes the value of `din` (any code 0 to 15) on the next clock edge. A count edge in that cycle is dropped.
- R3: With `clr` low and `load_n` high, `q` holds when no qualified count edge is seen. If both count inputs rise in the same cycle, nothing is counted.
- R4: A rising edge on `count_up` while `count_dn` is high adds one to codes 0 to 8. From 9 it goes to 0.
- R5: A rising edge on `count_dn` while `count_up` is high subtracts one from codes 1 to 9. From 0 it goes to 9.
- R6: Counting up from a code above nine gives 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2.
- R7: Counting down from any code 10 to 15 gives that code minus one.
- R8: `carry_n` is low exactly while `count_up` is low and `q` is 9. Otherwise it is high.
- R9: `borrow_n` is low exactly while `count_dn` is low and `q` is 0. Otherwise it is high.
- R10: When two digits are chained (`carry_n` to the next `count_up`, `borrow_n` to the next `count_dn`), the pair counts modulo 100 in both directions. This includes crossing the 99/00 boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous system reset for the block's registers |
| clr | input | 1 | Master clear, active high, highest priority |
| load_n | input | 1 | Parallel load, active low, level sensitive |
| din | input | DIGIT_W | Value written by the parallel load |
| count_up | input | 1 | Up-count input, acts on its rising edge |
| count_dn | input | 1 | Down-count input, acts on its rising edge |
| q | output | DIGIT_W | Current digit |
| carry_n | output | 1 | Active-low terminal-up output for chaining |
| borrow_n | output | 1 | Active-low terminal-down output for chaining |

## Verification
The assertions assume that the count inputs change only between system clock edges. They also assume that a count pulse stays low for at least one sampled cycle, so that its rising edge is seen once. The bench drives every input on the falling clock edge. Each count pulse is exactly one cycle low and then returns high. Clear and load pulses are one cycle wide, and random din values cover all sixteen codes. Because of this, a chained second digit sees clean edges on the carry and borrow lines.

// File: rtl/bcd_updn_pkg.sv
package bcd_updn_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_code_t;

   // operation applied to the digit on a clock edge, in priority order
   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CLEAR = 3'd1,
      OP_LOAD  = 3'd2,
      OP_INC   = 3'd3,
      OP_DEC   = 3'd4
   } bcd_op_e;
endpackage

// File: rtl/bcd_edge_sense.sv
module bcd_edge_sense #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise
);
   logic prev_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("bcd_edge_sense: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], pin} >> 0;
         end
         assign level = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
endmodule

// File: rtl/bcd_step_logic.sv
module bcd_step_logic
   import bcd_updn_pkg::*;
(
   input  bcd_code_t cur,
   output bcd_code_t nxt_up,
   output bcd_code_t nxt_dn
);
   localparam bcd_code_t TOP_CODE = bcd_code_t'(9);

   always_comb begin
      unique case (cur)
         4'd9:    nxt_up = 4'd0;
         4'd11:   nxt_up = 4'd6;
         4'd13:   nxt_up = 4'd4;
         4'd15:   nxt_up = 4'd2;
         default: nxt_up = cur + 4'd1;   // 0..8, 10, 12, 14
      endcase
   end

   always_comb begin
      if (cur == '0) nxt_dn = TOP_CODE;
      else           nxt_dn = cur - 4'd1;  // also 10..15
   end
endmodule

// File: rtl/bcd_updn_counter.sv
module bcd_updn_counter
   import bcd_updn_pkg::*;
#(
   parameter int DIGIT_W     = 4,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               load_n,
   input  logic [DIGIT_W-1:0] din,
   input  logic               count_up,
   input  logic               count_dn,
   output logic [DIGIT_W-1:0] q,
   output logic               carry_n,
   output logic               borrow_n
);
   localparam logic [DIGIT_W-1:0] TOP_CODE  = DIGIT_W'(9);
   localparam logic [DIGIT_W-1:0] ZERO_CODE = '0;

   generate
      if (DIGIT_W != BCD_W) begin : g_width_chk
         $error("bcd_updn_counter: DIGIT_W must equal 4 for a BCD digit");
      end
   endgenerate

   logic up_lvl, up_rise, dn_lvl, dn_rise;
   logic up_ok, dn_ok;
   bcd_code_t nxt_up, nxt_dn, cnt_q;
   bcd_op_e   op;

   bcd_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_up_edge (
      .clk(clk), .rst_n(rst_n), .pin(count_up), .level(up_lvl), .rise(up_rise)
   );
   bcd_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_dn_edge (
      .clk(clk), .rst_n(rst_n), .pin(count_dn), .level(dn_lvl), .rise(dn_rise)
   );

   bcd_step_logic u_step (.cur(cnt_q), .nxt_up(nxt_up), .nxt_dn(nxt_dn));

   // an edge counts only while the opposite input sits high and is not rising too
   assign up_ok = up_rise & dn_lvl & ~dn_rise;
   assign dn_ok = dn_rise & up_lvl & ~up_rise;

   always_comb begin
      if (clr)          op = OP_CLEAR;
      else if (!load_n) op = OP_LOAD;
      else if (up_ok)   op = OP_INC;
      else if (dn_ok)   op = OP_DEC;
      else              op = OP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         unique case (op)
            OP_CLEAR: cnt_q <= '0;
            OP_LOAD:  cnt_q <= din;
            OP_INC:   cnt_q <= nxt_up;
            OP_DEC:   cnt_q <= nxt_dn;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign q        = cnt_q;
   assign carry_n  = ~(~up_lvl & (cnt_q == TOP_CODE));
   assign borrow_n = ~(~dn_lvl & (cnt_q == ZERO_CODE));

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == ZERO_CODE);

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && !load_n |=> q == $past(din));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && !up_rise && !dn_rise |=> $stable(q));

   p_both_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && up_rise && dn_rise |=> $stable(q));

   p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && up_ok && q == TOP_CODE |=> q == ZERO_CODE);

   p_dn_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && dn_ok && q == ZERO_CODE |=> q == TOP_CODE);

   p_recover_15_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && up_ok && q == 4'd15 |=> q == 4'd2);

   p_illegal_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr && load_n && dn_ok && q > TOP_CODE |=> q == $past(q) - 4'd1);

   p_carry_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      count_up |-> carry_n);

   p_borrow_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_dn |-> borrow_n);
endmodule

// File: tb/tb_bcd_updn_counter.sv
`timescale 1ns/1ps
module tb_bcd_updn_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0, load_n = 1'b1;
   logic [3:0] din = '0, din_hi = '0;
   logic       count_up = 1'b1, count_dn = 1'b1;
   logic [3:0] q, q_hi;
   logic       carry_n, borrow_n, carry_hi_n, borrow_hi_n;

   int checks = 0, errors = 0;
   int exp_lo = 0, exp_hi = 0;

   always #10 clk = ~clk;   // 50 MHz

   bcd_updn_counter dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
      .count_up(count_up), .count_dn(count_dn),
      .q(q), .carry_n(carry_n), .borrow_n(borrow_n)
   );
   bcd_updn_counter dut_hi (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din_hi),
      .count_up(carry_n), .count_dn(borrow_n),
      .q(q_hi), .carry_n(carry_hi_n), .borrow_n(borrow_hi_n)
   );

   function automatic int m_up(int v);
      case (v)
         9: return 0;  11: return 6;  13: return 4;  15: return 2;
         default: return v + 1;
      endcase
   endfunction

   function automatic int m_dn(int v);
      return (v == 0) ? 9 : v - 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_state(input string req);
      chk(req, q, exp_lo);
      chk({req, " (upper digit)"}, q_hi, exp_hi);
      chk("R8 idle", carry_n, 1);
      chk("R9 idle", borrow_n, 1);
   endtask

   task automatic do_up(input string req);
      @(negedge clk); count_up = 1'b0; #1;
      chk("R8", carry_n, (exp_lo == 9) ? 0 : 1);
      @(negedge clk); count_up = 1'b1;
      if (exp_lo == 9) exp_hi = m_up(exp_hi);
      exp_lo = m_up(exp_lo);
      @(negedge clk); chk_state(req);
   endtask

   task automatic do_dn(input string req);
      @(negedge clk); count_dn = 1'b0; #1;
      chk("R9", borrow_n, (exp_lo == 0) ? 0 : 1);
      @(negedge clk); count_dn = 1'b1;
      if (exp_lo == 0) exp_hi = m_dn(exp_hi);
      exp_lo = m_dn(exp_lo);
      @(negedge clk); chk_state(req);
   endtask

   task automatic do_load(input int lo, input int hi, input bit with_up);
      @(negedge clk); if (with_up) count_up = 1'b0;
      @(negedge clk); load_n = 1'b0; din = 4'(lo); din_hi = 4'(hi); count_up = 1'b1;
      @(negedge clk); load_n = 1'b1;
      exp_lo = lo; exp_hi = hi;
      chk_state("R2");
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1; load_n = 1'b0; din = 4'd7; din_hi = 4'd7;
      @(negedge clk); clr = 1'b0; load_n = 1'b1;
      exp_lo = 0; exp_hi = 0;
      chk_state("R1");
   endtask

   task automatic do_both();
      @(negedge clk); count_up = 1'b0; count_dn = 1'b0;
      @(negedge clk); count_up = 1'b1; count_dn = 1'b1;
      // lower digit ignores the pair; the upper digit sees one chained edge
      if (exp_lo == 9) exp_hi = m_up(exp_hi);
      if (exp_lo == 0) exp_hi = m_dn(exp_hi);
      @(negedge clk); chk_state("R3 both");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unused_seed;
      unused_seed = $urandom(32'h5eed_0b1d);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R3 reset");
      repeat (4) @(negedge clk);
      chk_state("R3 idle");

      // R4 / R10: full upward sweep across 99 -> 00
      for (int i = 0; i < 101; i++) do_up("R4 R10");
      // R5 / R10: downward sweep across 00 -> 99
      for (int i = 0; i < 103; i++) do_dn("R5 R10");

      // R6 and R7: every code above nine in both directions
      for (int c = 10; c < 16; c++) begin
         do_load(c, 3, 1'b0); do_up("R6");
         do_load(c, 3, 1'b0); do_dn("R7");
      end
      // R6: two ups from 12, and recovery from 15 to the decade
      do_load(12, 0, 1'b0); do_up("R6"); do_up("R6");
      chk("R6 12->4", q, 4);
      do_load(15, 0, 1'b0); do_up("R6"); do_up("R6");

      // R2: load overrides a count edge in the same cycle
      do_load(9, 5, 1'b1);
      // R1: clear overrides load
      do_clear();
      do_both();
      do_load(9, 2, 1'b0); do_both();

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int sel;
         sel = int'($urandom_range(0, 19));
         if (sel < 8)       do_up("R4 rand");
         else if (sel < 16) do_dn("R5 rand");
         else if (sel < 18) do_load(int'($urandom_range(0, 15)), int'($urandom_range(0, 9)), sel[0]);
         else if (sel < 19) do_clear();
         else               do_both();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule